// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block holds the interrupt and exception control state of a small RISC core and steers the program counter when the core takes an exception. It owns a status word with a single global interrupt-enable bit, a saved copy of that word, a return-address register, a per-line interrupt mask and a read-only pending view. The pending view is the 32 level-sensitive request lines gated by the mask. It is forced to zero while the core is single-stepping under a debugger.

An exception is taken when a software trap is requested, or when interrupts are globally enabled and at least one masked line is pending. On entry the controller copies the status word into the saved copy, clears the live enable bit and records the next-PC supplied by the pipeline. One cycle later it issues a redirect to a single fixed handler address. The address is the same for every cause, and the lines carry no priority in hardware. An exception-return request puts the saved status back and redirects to the recorded address. Software reaches the registers through a small indexed control-register port with a combinational read and a synchronous write.

Top module: `eh_top`

## Requirements
- R1: After reset the enable bit (status index 0, bit 0), the saved status (index 1), the mask (index 2), the return address (index 4) and the redirect output are all zero.
- R2: Reading index 3 returns the request lines ANDed with the mask, in the same cycle the lines change.
- R3: While the single-step input is high, index 3 reads zero and no interrupt is taken, even with interrupts enabled and lines pending.
- R4: An interrupt is taken only when the enable bit is 1 and the pending view is nonzero; with the enable bit at 0 no redirect occurs.
- R5: A trap request is taken whatever the state of the enable bit.
- R6: On entry the saved status receives the enable bit as it was, and the live enable bit is cleared.
- R7: On entry the return address (index 4) receives the next-PC input sampled in the entry cycle.
- R8: The cycle after entry the redirect output is high for one cycle with the handler address parameter on the redirect PC, for interrupt and trap alike.
- R9: A return request restores the enable bit from the saved status and, one cycle later, redirects to the return address.
- R10: When an entry coincides with a return request or with a control write to index 0, 1 or 4, the entry wins and the other is dropped.
- R11: Control writes take effect at the next clock edge; writes to index 3 and 4 are ignored, and status bits other than bit 0 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| next_pc_i | input | 32 | Address of the next instruction to run |
| irq_i | input | 32 | Level interrupt request lines |
| trap_i | input | 1 | Software trap request |
| eret_i | input | 1 | Exception-return request |
| step_i | input | 1 | Debug single-step active |
| cr_wr_i | input | 1 | Control-register write strobe |
| cr_idx_i | input | 3 | Control-register index |
| cr_wdata_i | input | 32 | Control-register write data |
| cr_rdata_o | output | 32 | Control-register read data (combinational) |
| redirect_o | output | 1 | PC redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |

## Verification
The pending read is combinational, so the bench samples index 3 one time step after changing the lines, before any clock edge. Entry and return update the registers at the accepting edge and the redirect output in the cycle after it; the bench drives each request two time units after a rising edge, waits one edge and then reads the redirect and the saved registers together. Suppression cases (single-step, enable off) are checked across two following cycles so a late redirect would also be seen.

// File: rtl/eh_pkg.sv
// Package: shared control-register index encoding for the exception controller.
// Assumes a 3-bit index port; unused indices read zero.
package eh_pkg;
    localparam int CR_IDX_W = 3;

    typedef enum logic [CR_IDX_W-1:0] {
        CR_STATUS  = 3'd0,
        CR_SAVED   = 3'd1,
        CR_MASK    = 3'd2,
        CR_PENDING = 3'd3,
        CR_RETADDR = 3'd4
    } cr_idx_e;

    // bit position of the global interrupt enable inside the status word
    localparam int IE_BIT = 0;
endpackage

// File: rtl/eh_pending.sv
// Pending view: each request line gated by its mask bit and by the
// single-step flag. Purely combinational; assumes level-sensitive lines.
module eh_pending #(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] mask_i,
    input  logic               step_i,
    output logic [NUM_IRQ-1:0] pend_o,
    output logic               any_o
);
    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_line
            // one gate per line: request, mask and debug suppression
            assign pend_o[g] = irq_i[g] & mask_i[g] & ~step_i;
        end
    endgenerate

    // reduction for the entry decision
    assign any_o = |pend_o;
endmodule

// File: rtl/eh_ctrl_regs.sv
// Control state: enable bit, saved enable bit, return address and mask.
// Entry has precedence over return and over software writes to the
// registers it touches. Assumes accept_i and eret_i are single-cycle.
module eh_ctrl_regs
    import eh_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  logic                eret_i,
    input  logic [XLEN-1:0]     next_pc_i,
    input  logic                wr_en_i,
    input  logic [CR_IDX_W-1:0] wr_idx_i,
    input  logic [XLEN-1:0]     wr_data_i,
    output logic                ie_o,
    output logic                eie_o,
    output logic [XLEN-1:0]     ea_o,
    output logic [NUM_IRQ-1:0]  mask_o
);
    logic                ie_q, eie_q;
    logic [XLEN-1:0]     ea_q;
    logic [NUM_IRQ-1:0]  mask_q;
    logic                wr_status, wr_saved, wr_mask;

    // decode the software write strobes
    always_comb begin
        wr_status = wr_en_i && (wr_idx_i == CR_STATUS);
        wr_saved  = wr_en_i && (wr_idx_i == CR_SAVED);
        wr_mask   = wr_en_i && (wr_idx_i == CR_MASK);
    end

    // enable and saved-enable bits: entry, then return, then software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            eie_q <= 1'b0;
        end else if (accept_i) begin
            eie_q <= ie_q;
            ie_q  <= 1'b0;
        end else if (eret_i) begin
            ie_q  <= eie_q;
        end else begin
            if (wr_status) ie_q  <= wr_data_i[IE_BIT];
            if (wr_saved)  eie_q <= wr_data_i[IE_BIT];
        end
    end

    // return address captured only on entry
    always_ff @(posedge clk) begin
        if (!rst_n)        ea_q <= '0;
        else if (accept_i) ea_q <= next_pc_i;
    end

    // mask register, software written only
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wr_data_i[NUM_IRQ-1:0];
    end

    assign ie_o   = ie_q;
    assign eie_o  = eie_q;
    assign ea_o   = ea_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/eh_redirect.sv
// Redirect register: one-cycle pulse with the target PC, the cycle after
// an entry (fixed handler address) or a return (saved address).
module eh_redirect #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] EXC_ADDR = 32'h0000_0020
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic            eret_i,
    input  logic [XLEN-1:0] ea_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] pc_o
);
    logic            vld_q;
    logic [XLEN-1:0] pc_q;

    // register the redirect; entry overrides a coincident return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            pc_q  <= '0;
        end else begin
            vld_q <= accept_i | eret_i;
            if (accept_i)    pc_q <= EXC_ADDR;
            else if (eret_i) pc_q <= ea_i;
        end
    end

    assign redirect_o = vld_q;
    assign pc_o       = pc_q;
endmodule

// File: rtl/eh_top.sv
// Exception entry controller top: decides entry, holds control state,
// serves the indexed control-register port and drives the PC redirect.
// Assumes NUM_IRQ <= XLEN so the mask fits one control word.
module eh_top
    import eh_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              NUM_IRQ  = 32,
    parameter logic [XLEN-1:0] EXC_ADDR = 32'h0000_0020
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XLEN-1:0]     next_pc_i,
    input  logic [NUM_IRQ-1:0]  irq_i,
    input  logic                trap_i,
    input  logic                eret_i,
    input  logic                step_i,
    input  logic                cr_wr_i,
    input  logic [CR_IDX_W-1:0] cr_idx_i,
    input  logic [XLEN-1:0]     cr_wdata_i,
    output logic [XLEN-1:0]     cr_rdata_o,
    output logic                redirect_o,
    output logic [XLEN-1:0]     redirect_pc_o
);
    localparam int PAD_W = XLEN - NUM_IRQ;

    logic                accept_w, ie_w, eie_w, any_w;
    logic [XLEN-1:0]     ea_w;
    logic [NUM_IRQ-1:0]  mask_w, pend_w;
    logic [XLEN-1:0]     mask_x, pend_x;

    eh_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .irq_i  (irq_i),
        .mask_i (mask_w),
        .step_i (step_i),
        .pend_o (pend_w),
        .any_o  (any_w)
    );

    // entry decision: trap always, interrupt when enabled and pending
    assign accept_w = trap_i | (ie_w & any_w);

    eh_ctrl_regs #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept_w),
        .eret_i    (eret_i),
        .next_pc_i (next_pc_i),
        .wr_en_i   (cr_wr_i),
        .wr_idx_i  (cr_idx_i),
        .wr_data_i (cr_wdata_i),
        .ie_o      (ie_w),
        .eie_o     (eie_w),
        .ea_o      (ea_w),
        .mask_o    (mask_w)
    );

    eh_redirect #(.XLEN(XLEN), .EXC_ADDR(EXC_ADDR)) u_redir (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept_w),
        .eret_i     (eret_i),
        .ea_i       (ea_w),
        .redirect_o (redirect_o),
        .pc_o       (redirect_pc_o)
    );

    // widen the line-sized vectors to a control word
    generate
        if (PAD_W > 0) begin : g_pad
            assign mask_x = {{PAD_W{1'b0}}, mask_w};
            assign pend_x = {{PAD_W{1'b0}}, pend_w};
        end else begin : g_nopad
            assign mask_x = mask_w;
            assign pend_x = pend_w;
        end
    endgenerate

    // combinational control-register read mux
    always_comb begin
        cr_rdata_o = '0;
        case (cr_idx_i)
            CR_STATUS:  cr_rdata_o[IE_BIT] = ie_w;
            CR_SAVED:   cr_rdata_o[IE_BIT] = eie_w;
            CR_MASK:    cr_rdata_o = mask_x;
            CR_PENDING: cr_rdata_o = pend_x;
            CR_RETADDR: cr_rdata_o = ea_w;
            default:    cr_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/eh_checker.sv
// Checker for eh_top: temporal properties on ports and internal state.
module eh_checker #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] EXC_ADDR = 32'h0000_0020
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_i,
    input logic            eret_i,
    input logic            step_i,
    input logic [2:0]      cr_idx_i,
    input logic [XLEN-1:0] cr_rdata_o,
    input logic [XLEN-1:0] next_pc_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic            accept,
    input logic            ie,
    input logic            eie,
    input logic [XLEN-1:0] ea
);
    AST_STEP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cr_idx_i == 3'd3) |-> (cr_rdata_o == '0)); // R3
    AST_STEP_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !trap_i && !eret_i) |=> !redirect_o); // R3
    AST_DISABLED_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && !trap_i && !eret_i) |=> !redirect_o); // R4
    AST_TRAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i |=> (redirect_o && redirect_pc_o == EXC_ADDR)); // R5
    AST_ENTRY_SAVES_IE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!ie && eie == $past(ie))); // R6
    AST_ENTRY_EA: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ea == $past(next_pc_i))); // R7
    AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !accept) |=> (ie == $past(eie) && redirect_o && redirect_pc_o == $past(ea))); // R9
endmodule

bind eh_top eh_checker #(.XLEN(XLEN), .EXC_ADDR(EXC_ADDR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_i        (trap_i),
    .eret_i        (eret_i),
    .step_i        (step_i),
    .cr_idx_i      (cr_idx_i),
    .cr_rdata_o    (cr_rdata_o),
    .next_pc_i     (next_pc_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .accept        (accept_w),
    .ie            (ie_w),
    .eie           (eie_w),
    .ea            (ea_w)
);

// File: tb/sim_eh_top.sv
// Bench: pending-view vector table, then directed entry/return cases.
module sim_eh_top;
    localparam logic [31:0] EXC = 32'h0000_0020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] next_pc = '0;
    logic [31:0] irq = '0;
    logic        trap = 1'b0, eret = 1'b0, step = 1'b0, wr = 1'b0;
    logic [2:0]  idx = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rpc;
    logic        redir;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    // {mask, lines, expected pending}
    localparam logic [95:0] VEC [6] = '{
        {32'hFFFF_FFFF, 32'h8000_0001, 32'h8000_0001},
        {32'h0000_00FF, 32'h0000_0F0F, 32'h0000_000F},
        {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000},
        {32'hF0F0_0000, 32'hFFFF_0000, 32'hF0F0_0000},
        {32'h0000_0001, 32'h0000_0001, 32'h0000_0001}
    };

    eh_top #(.EXC_ADDR(EXC)) u0 (
        .clk(clk), .rst_n(rst_n), .next_pc_i(next_pc), .irq_i(irq),
        .trap_i(trap), .eret_i(eret), .step_i(step), .cr_wr_i(wr),
        .cr_idx_i(idx), .cr_wdata_i(wdata), .cr_rdata_o(rdata),
        .redirect_o(redir), .redirect_pc_o(rpc)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic rd(input logic [2:0] i, output logic [31:0] v);
        wr  = 1'b0;
        idx = i;
        #1;
        v = rdata;
    endtask

    task automatic wcr(input logic [2:0] i, input logic [31:0] d);
        wr = 1'b1; idx = i; wdata = d;
        cyc();
        wr = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) cyc();
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 status", v, 0);
        rd(3'd1, v); chk("R1 saved", v, 0);
        rd(3'd2, v); chk("R1 mask", v, 0);
        rd(3'd4, v); chk("R1 retaddr", v, 0);
        chk("R1 redirect", {31'd0, redir}, 0);

        // R2 pending view table
        for (int k = 0; k < 6; k++) begin
            wcr(3'd2, VEC[k][95:64]);
            irq = VEC[k][63:32];
            rd(3'd3, v); chk("R2 pending", v, VEC[k][31:0]);
        end
        irq = '0;

        // R4 lines pending but enable clear
        wcr(3'd2, 32'hFFFF_FFFF);
        irq = 32'h0000_0004;
        cyc(); chk("R4 no redirect", {31'd0, redir}, 0);
        cyc(); chk("R4 no redirect 2", {31'd0, redir}, 0);

        // R3 single-step suppresses
        step = 1'b1;
        wcr(3'd0, 32'h1);
        rd(3'd3, v); chk("R3 pending zero", v, 0);
        cyc(); chk("R3 no redirect", {31'd0, redir}, 0);
        cyc(); chk("R3 no redirect 2", {31'd0, redir}, 0);
        rd(3'd0, v); chk("R3 ie kept", v, 1);

        // R4/R6/R7/R8 interrupt entry
        next_pc = 32'h0000_1234;
        step = 1'b0;
        cyc();
        irq = '0;
        chk("R8 redirect", {31'd0, redir}, 1);
        chk("R8 target", rpc, EXC);
        rd(3'd0, v); chk("R6 ie cleared", v, 0);
        rd(3'd1, v); chk("R6 saved ie", v, 1);
        rd(3'd4, v); chk("R7 retaddr", v, 32'h0000_1234);
        cyc(); chk("R8 single pulse", {31'd0, redir}, 0);

        // R9 return
        next_pc = 32'h0000_9999;
        eret = 1'b1;
        cyc();
        eret = 1'b0;
        chk("R9 redirect", {31'd0, redir}, 1);
        chk("R9 target", rpc, 32'h0000_1234);
        rd(3'd0, v); chk("R9 ie restored", v, 1);

        // R5 trap with enable set, then with enable clear
        trap = 1'b1; next_pc = 32'h0000_0040;
        cyc(); trap = 1'b0;
        chk("R5 trap redirect", {31'd0, redir}, 1);
        chk("R5 trap target", rpc, EXC);
        trap = 1'b1; next_pc = 32'h0000_0080;
        cyc(); trap = 1'b0;
        chk("R5 trap ie0 redirect", {31'd0, redir}, 1);
        chk("R8 trap target", rpc, EXC);
        rd(3'd1, v); chk("R6 saved ie0", v, 0);
        rd(3'd4, v); chk("R7 trap retaddr", v, 32'h0000_0080);

        // R10 entry beats return and status write
        trap = 1'b1; eret = 1'b1; wr = 1'b1; idx = 3'd0; wdata = 32'h1;
        next_pc = 32'h0000_0100;
        cyc();
        trap = 1'b0; eret = 1'b0; wr = 1'b0;
        chk("R10 redirect", {31'd0, redir}, 1);
        chk("R10 target", rpc, EXC);
        rd(3'd0, v); chk("R10 write dropped", v, 0);
        rd(3'd4, v); chk("R10 retaddr", v, 32'h0000_0100);

        // R11 ignored writes and sync timing
        wcr(3'd2, 32'h0000_0010);
        irq = 32'h0000_0010;
        wcr(3'd3, 32'h0);
        rd(3'd3, v); chk("R11 pending write ignored", v, 32'h0000_0010);
        wcr(3'd0, 32'hFFFF_FFFE);
        rd(3'd0, v); chk("R11 status upper zero", v, 0);
        wcr(3'd4, 32'hDEAD_BEEF);
        rd(3'd4, v); chk("R11 retaddr write ignored", v, 32'h0000_0100);
        wr = 1'b1; idx = 3'd2; wdata = 32'h3;
        #1; chk("R11 before edge", rdata, 32'h0000_0010);
        cyc(); wr = 1'b0;
        rd(3'd2, v); chk("R11 after edge", v, 32'h3);
        irq = '0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule